// File: doc/BRIEF.md
# Two-Stage Latched Interrupt Aggregator

This block collects interrupt requests in two cascaded stages and presents a single upstream interrupt line. The first stage captures seventeen serial interrupt request lines and nine bus event inputs into a sticky status register. It masks that status and qualifies the result with a global enable bit. The resulting first-stage request is copied into one bit of the second stage's input register. The second stage latches its masked inputs into a sticky status register of its own, and the upstream interrupt follows that status.

Each stage has its own 32-bit register port with a write strobe, a byte address, write data and combinational read data. Status bits in both stages are cleared by writing ones to them. A status bit stays set after its source goes low, so software sees every event until it acknowledges it. The serial frame decoder that drives the request lines and the interrupt controller that receives the output are outside this block.

Top module: `irq_cascade`

## Requirements
- R1: After reset, every stored register in both stages reads zero and `irq_out` is low.
- R2: A high level on `ser_irq[n]` at a clock edge sets first-stage status bit 31-n. Status therefore uses bits 31 down to 15 for the serial lines. The bit stays set when the line returns low.
- R3: Event inputs set first-stage status bits on the same edge: `bus_evt[8]` sets bit 10 (link reset) and `bus_evt[k]` sets bit k for k from 0 to 7.
- R4: The error address register at offset 0x40 loads `bus_err_addr` on any edge where one of `bus_evt[7:2]` is high. Events on `bus_evt[1:0]` and `bus_evt[8]` do not load it, and writes to offset 0x40 do not change it.
- R5: Writing to first-stage offset 0x38 clears each status bit whose write-data bit is 1. If a source sets a bit in the same cycle that it is cleared, the bit ends up set.
- R6: The first-stage request is high only while control bit 31 (offset 0x30) is 1 and the AND of status with the mask register (offset 0x34) is nonzero. The control register keeps only bits 31, 30 and 25:24 and reads zero elsewhere. Bits 30 and 25:24 have no effect on the request.
- R7: Bit 11 of the second-stage input register (offset 0x5C) shows the first-stage request one clock later. All other bits of that register read zero, and writes to it are ignored.
- R8: Second-stage status (offset 0x50) gains input AND mask (mask at offset 0x54) on every clock. A latched bit stays set after its input falls. Writing ones to offset 0x50 clears the matching bits, but a bit that is being set in the same cycle stays set.
- R9: `irq_out` is high exactly while second-stage status is nonzero.
- R10: The second-stage registers at offsets 0x08, 0x0C and 0x58 store all 32 written bits and read them back. Their contents do not affect status or `irq_out`.
- R11: In either stage, a read from an offset that holds no register returns 0xFFFFFFFF, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_irq | input | 17 | Decoded serial interrupt request levels |
| bus_evt | input | 9 | Bus error and event pulses (bit 8 link reset, bits 7..0 sync/turnaround/request events) |
| bus_err_addr | input | 32 | Address of the bus cycle that raised an error event |
| s1_we | input | 1 | First-stage register write strobe |
| s1_addr | input | 8 | First-stage register byte offset |
| s1_wdata | input | 32 | First-stage write data |
| s1_rdata | output | 32 | First-stage read data for `s1_addr` |
| s2_we | input | 1 | Second-stage register write strobe |
| s2_addr | input | 8 | Second-stage register byte offset |
| s2_wdata | input | 32 | Second-stage write data |
| s2_rdata | output | 32 | Second-stage read data for `s2_addr` |
| irq_out | output | 1 | Upstream interrupt request |

## Verification
The properties assume that request and event inputs are levels sampled only at clock edges. They also assume that a write strobe lasts exactly one cycle with a stable address and data. The stimulus changes every input on the falling edge and holds each write for one full cycle. The properties also take the first-stage request to be the sole source of second-stage input bit 11, so the bench reaches the second stage only through the first-stage register port and the request lines. Set-versus-clear collisions are produced deliberately in both stages by keeping a source high during the acknowledging write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DW       = 32;
    localparam int SER_W    = 17;
    localparam int EVT_W    = 9;
    localparam int OFF_W    = 8;

    // first stage offsets
    localparam logic [OFF_W-1:0] S1_CTRL_OFF = 8'h30;
    localparam logic [OFF_W-1:0] S1_MASK_OFF = 8'h34;
    localparam logic [OFF_W-1:0] S1_STAT_OFF = 8'h38;
    localparam logic [OFF_W-1:0] S1_EADR_OFF = 8'h40;

    // second stage offsets
    localparam logic [OFF_W-1:0] S2_RT0_OFF  = 8'h08;
    localparam logic [OFF_W-1:0] S2_RT1_OFF  = 8'h0C;
    localparam logic [OFF_W-1:0] S2_STAT_OFF = 8'h50;
    localparam logic [OFF_W-1:0] S2_MASK_OFF = 8'h54;
    localparam logic [OFF_W-1:0] S2_POL_OFF  = 8'h58;
    localparam logic [OFF_W-1:0] S2_IN_OFF   = 8'h5C;

    localparam logic [DW-1:0] CTRL_KEEP   = 32'hC300_0000;
    localparam int            CTRL_EN_BIT = 31;
    localparam int            LNKRST_BIT  = 10;
    localparam int            ERR_LO      = 2;
    localparam int            ERR_HI      = 7;
    localparam int            S2_SRC_BIT  = 11;
    localparam logic [DW-1:0] UNMAPPED    = '1;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] mask;
        logic [DW-1:0] eaddr;
    } s1_regs_t;

    typedef struct packed {
        logic [DW-1:0] rt0;
        logic [DW-1:0] rt1;
        logic [DW-1:0] mask;
        logic [DW-1:0] pol;
        logic [DW-1:0] inp;
    } s2_regs_t;

endpackage

// File: rtl/irqc_sticky.sv
module irqc_sticky #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] lat_d, lat_q;

    // a set in the same cycle as a clear leaves the bit set
    always_comb begin
        lat_d = (lat_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign q_o = lat_q;
endmodule

// File: rtl/irqc_s1_stage.sv
module irqc_s1_stage
    import irqc_pkg::*;
#(
    parameter int AW = OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SER_W-1:0] ser_irq,
    input  logic [EVT_W-1:0] evt,
    input  logic [DW-1:0]    err_addr,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    stat_o,
    output logic [DW-1:0]    mask_o,
    output logic [DW-1:0]    ctrl_o,
    output logic             req_o
);
    s1_regs_t     r_d, r_q;
    logic [DW-1:0] set_v, clr_v, stat;

    always_comb begin
        set_v = '0;
        for (int n = 0; n < SER_W; n++) begin
            set_v[DW-1-n] = ser_irq[n];
        end
        set_v[ERR_HI:0]   = evt[ERR_HI:0];
        set_v[LNKRST_BIT] = evt[EVT_W-1];
    end

    always_comb begin
        clr_v = (we && addr == AW'(S1_STAT_OFF)) ? wdata : '0;
    end

    irqc_sticky #(.W(DW)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .q_o   (stat)
    );

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr == AW'(S1_CTRL_OFF)) r_d.ctrl = wdata & CTRL_KEEP;
            if (addr == AW'(S1_MASK_OFF)) r_d.mask = wdata;
        end
        if (|evt[ERR_HI:ERR_LO]) r_d.eaddr = err_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        if      (addr == AW'(S1_CTRL_OFF)) rdata = r_q.ctrl;
        else if (addr == AW'(S1_MASK_OFF)) rdata = r_q.mask;
        else if (addr == AW'(S1_STAT_OFF)) rdata = stat;
        else if (addr == AW'(S1_EADR_OFF)) rdata = r_q.eaddr;
        else                               rdata = UNMAPPED;
    end

    assign req_o  = r_q.ctrl[CTRL_EN_BIT] & (|(stat & r_q.mask));
    assign stat_o = stat;
    assign mask_o = r_q.mask;
    assign ctrl_o = r_q.ctrl;
endmodule

// File: rtl/irqc_s2_stage.sv
module irqc_s2_stage
    import irqc_pkg::*;
#(
    parameter int AW = OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] stat_o,
    output logic [DW-1:0] mask_o,
    output logic [DW-1:0] inp_o
);
    s2_regs_t      r_d, r_q;
    logic [DW-1:0] set_v, clr_v, stat;

    always_comb begin
        r_d = r_q;
        r_d.inp = '0;
        r_d.inp[S2_SRC_BIT] = src_req;
        if (we) begin
            if (addr == AW'(S2_RT0_OFF))  r_d.rt0  = wdata;
            if (addr == AW'(S2_RT1_OFF))  r_d.rt1  = wdata;
            if (addr == AW'(S2_MASK_OFF)) r_d.mask = wdata;
            if (addr == AW'(S2_POL_OFF))  r_d.pol  = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        set_v = r_q.inp & r_q.mask;
        clr_v = (we && addr == AW'(S2_STAT_OFF)) ? wdata : '0;
    end

    irqc_sticky #(.W(DW)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .q_o   (stat)
    );

    always_comb begin
        if      (addr == AW'(S2_RT0_OFF))  rdata = r_q.rt0;
        else if (addr == AW'(S2_RT1_OFF))  rdata = r_q.rt1;
        else if (addr == AW'(S2_STAT_OFF)) rdata = stat;
        else if (addr == AW'(S2_MASK_OFF)) rdata = r_q.mask;
        else if (addr == AW'(S2_POL_OFF))  rdata = r_q.pol;
        else if (addr == AW'(S2_IN_OFF))   rdata = r_q.inp;
        else                               rdata = UNMAPPED;
    end

    assign stat_o = stat;
    assign mask_o = r_q.mask;
    assign inp_o  = r_q.inp;
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SER_W-1:0] ser_irq,
    input  logic [EVT_W-1:0] bus_evt,
    input  logic [DW-1:0]    bus_err_addr,
    input  logic             s1_we,
    input  logic [OFF_W-1:0] s1_addr,
    input  logic [DW-1:0]    s1_wdata,
    output logic [DW-1:0]    s1_rdata,
    input  logic             s2_we,
    input  logic [OFF_W-1:0] s2_addr,
    input  logic [DW-1:0]    s2_wdata,
    output logic [DW-1:0]    s2_rdata,
    output logic             irq_out
);
    logic          s1_req;
    logic [DW-1:0] s1_stat, s1_mask, s1_ctrl;
    logic [DW-1:0] s2_stat, s2_mask, s2_inp;

    irqc_s1_stage #(.AW(OFF_W)) u_s1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_irq  (ser_irq),
        .evt      (bus_evt),
        .err_addr (bus_err_addr),
        .we       (s1_we),
        .addr     (s1_addr),
        .wdata    (s1_wdata),
        .rdata    (s1_rdata),
        .stat_o   (s1_stat),
        .mask_o   (s1_mask),
        .ctrl_o   (s1_ctrl),
        .req_o    (s1_req)
    );

    irqc_s2_stage #(.AW(OFF_W)) u_s2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req (s1_req),
        .we      (s2_we),
        .addr    (s2_addr),
        .wdata   (s2_wdata),
        .rdata   (s2_rdata),
        .stat_o  (s2_stat),
        .mask_o  (s2_mask),
        .inp_o   (s2_inp)
    );

    assign irq_out = |s2_stat;
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SER_W-1:0] ser_irq,
    input logic [DW-1:0]    s1_stat,
    input logic [DW-1:0]    s1_ctrl,
    input logic [DW-1:0]    s2_inp,
    input logic [DW-1:0]    s2_mask,
    input logic [DW-1:0]    s2_stat,
    input logic             s2_we,
    input logic [OFF_W-1:0] s2_addr,
    input logic [DW-1:0]    s2_wdata,
    input logic             irq_out
);
    for (genvar n = 0; n < SER_W; n++) begin : g_ser
        // R2 / R5: a high request line always leaves its status bit set
        a_r2_line_latches: assert property (@(posedge clk) disable iff (!rst_n)
            ser_irq[n] |=> s1_stat[DW-1-n]);
    end

    // R6 / R7: with the enable bit low no request reaches the second stage
    a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_ctrl[CTRL_EN_BIT] |=> !s2_inp[S2_SRC_BIT]);

    // R8: masked input latches into second-stage status
    a_r8_masked_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_inp[S2_SRC_BIT] && s2_mask[S2_SRC_BIT]) |=> s2_stat[S2_SRC_BIT]);

    // R8: a latched bit only goes away through an acknowledging write
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_stat[S2_SRC_BIT] &&
         !(s2_we && s2_addr == S2_STAT_OFF && s2_wdata[S2_SRC_BIT]))
        |=> s2_stat[S2_SRC_BIT]);

    // R9: the upstream line drops only after a clearing write
    a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(s2_we && s2_addr == S2_STAT_OFF && (s2_wdata != '0)));
endmodule

bind irq_cascade irq_cascade_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_irq  (ser_irq),
    .s1_stat  (s1_stat),
    .s1_ctrl  (s1_ctrl),
    .s2_inp   (s2_inp),
    .s2_mask  (s2_mask),
    .s2_stat  (s2_stat),
    .s2_we    (s2_we),
    .s2_addr  (s2_addr),
    .s2_wdata (s2_wdata),
    .irq_out  (irq_out)
);

// File: tb/test_irq_cascade.sv
module test_irq_cascade;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] ser_irq = '0;
    logic [8:0]  bus_evt = '0;
    logic [31:0] bus_err_addr = '0;
    logic        s1_we = 1'b0;
    logic [7:0]  s1_addr = '0;
    logic [31:0] s1_wdata = '0;
    logic [31:0] s1_rdata;
    logic        s2_we = 1'b0;
    logic [7:0]  s2_addr = '0;
    logic [31:0] s2_wdata = '0;
    logic [31:0] s2_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  mon_ev;

    always #2 clk = ~clk;

    irq_cascade i_irq_cascade (
        .clk(clk), .rst_n(rst_n), .ser_irq(ser_irq), .bus_evt(bus_evt),
        .bus_err_addr(bus_err_addr),
        .s1_we(s1_we), .s1_addr(s1_addr), .s1_wdata(s1_wdata), .s1_rdata(s1_rdata),
        .s2_we(s2_we), .s2_addr(s2_addr), .s2_wdata(s2_wdata), .s2_rdata(s2_rdata),
        .irq_out(irq_out)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            item_t       it;
            logic [31:0] act;
            @(mon_ev);
            it = q.pop_front();
            case (it.kind)
                0:       act = s1_rdata;
                1:       act = s2_rdata;
                default: act = {31'b0, irq_out};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int stage, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (stage == 0) begin s1_we = 1'b1; s1_addr = a; s1_wdata = d; end
        else            begin s2_we = 1'b1; s2_addr = a; s2_wdata = d; end
        @(negedge clk);
        s1_we = 1'b0;
        s2_we = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        if (kind == 0) s1_addr = a;
        if (kind == 1) s2_addr = a;
        #1;
        it.kind = kind; it.exp = e; it.tag = tag;
        q.push_back(it);
        -> mon_ev;
        #1;
    endtask

    task automatic pulse_ser(input int n);
        @(negedge clk);
        ser_irq[n] = 1'b1;
        @(negedge clk);
        ser_irq[n] = 1'b0;
    endtask

    task automatic pulse_evt(input logic [8:0] e, input logic [31:0] ad);
        @(negedge clk);
        bus_evt = e; bus_err_addr = ad;
        @(negedge clk);
        bus_evt = '0; bus_err_addr = '0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        settle(4);
        rst_n = 1'b1;
        settle(2);

        // R1 reset state
        chk(0, 8'h30, 32'h0, "R1 s1 ctrl");
        chk(0, 8'h34, 32'h0, "R1 s1 mask");
        chk(0, 8'h38, 32'h0, "R1 s1 status");
        chk(0, 8'h40, 32'h0, "R1 s1 error address");
        chk(1, 8'h50, 32'h0, "R1 s2 status");
        chk(1, 8'h54, 32'h0, "R1 s2 mask");
        chk(1, 8'h5C, 32'h0, "R1 s2 input");
        chk(2, 8'h00, 32'h0, "R1 irq_out");
        // R11 unmapped reads
        chk(0, 8'h00, 32'hFFFF_FFFF, "R11 s1 unmapped read");
        chk(1, 8'h10, 32'hFFFF_FFFF, "R11 s2 unmapped read");

        // R2 serial lines latch
        pulse_ser(0);
        settle(2);
        chk(0, 8'h38, 32'h8000_0000, "R2 line 0 latched");
        pulse_ser(16);
        settle(3);
        chk(0, 8'h38, 32'h8000_8000, "R2 line 16 latched, line 0 held low");

        // R6 control register fields
        wr(0, 8'h30, 32'hFFFF_FFFF);
        chk(0, 8'h30, 32'hC300_0000, "R6 ctrl keeps only defined bits");
        wr(0, 8'h30, 32'h4300_0000);
        wr(0, 8'h34, 32'hFFFF_8000);
        settle(3);
        chk(1, 8'h5C, 32'h0, "R6 enable low blocks request");
        wr(0, 8'h30, 32'h8000_0000);
        settle(3);
        chk(1, 8'h5C, 32'h0000_0800, "R7 input mirrors stage one request");
        chk(1, 8'h50, 32'h0, "R8 unmasked input not latched");
        chk(2, 8'h00, 32'h0, "R9 irq low with empty status");

        wr(1, 8'h54, 32'h0000_0800);
        settle(2);
        chk(1, 8'h50, 32'h0000_0800, "R8 masked input latched");
        chk(2, 8'h00, 32'h1, "R9 irq high");

        wr(0, 8'h38, 32'hFFFF_FFFF);
        settle(3);
        chk(0, 8'h38, 32'h0, "R5 stage one clear");
        chk(1, 8'h5C, 32'h0, "R7 input follows request low");
        chk(1, 8'h50, 32'h0000_0800, "R8 status held after input drop");
        chk(2, 8'h00, 32'h1, "R9 irq held");

        wr(1, 8'h50, 32'h0000_0800);
        settle(1);
        chk(1, 8'h50, 32'h0, "R8 write one clears");
        chk(2, 8'h00, 32'h0, "R9 irq low after clear");

        // R3 / R4 events
        pulse_evt(9'h104, 32'hDEAD_0010);
        settle(1);
        chk(0, 8'h38, 32'h0000_0404, "R3 link reset and turnaround bits");
        chk(0, 8'h40, 32'hDEAD_0010, "R4 error address captured");
        pulse_evt(9'h002, 32'h0000_1111);
        settle(1);
        chk(0, 8'h38, 32'h0000_0406, "R3 request event bit");
        chk(0, 8'h40, 32'hDEAD_0010, "R4 non-error event keeps address");
        wr(0, 8'h40, 32'h0);
        chk(0, 8'h40, 32'hDEAD_0010, "R4 write to error address ignored");
        settle(2);
        chk(1, 8'h5C, 32'h0, "R6 masked-off status gives no request");
        wr(0, 8'h38, 32'hFFFF_FFFF);

        // R5 set wins over clear in stage one
        @(negedge clk);
        ser_irq[3] = 1'b1;
        s1_we = 1'b1; s1_addr = 8'h38; s1_wdata = 32'h1000_0000;
        @(negedge clk);
        s1_we = 1'b0;
        chk(0, 8'h38, 32'h1000_0000, "R5 set wins over clear");
        settle(3);
        chk(1, 8'h50, 32'h0000_0800, "R8 status from held line");

        // R8 set wins in stage two (line still high)
        wr(1, 8'h50, 32'h0000_0800);
        chk(1, 8'h50, 32'h0000_0800, "R8 set wins over clear");
        chk(2, 8'h00, 32'h1, "R9 irq stays high");

        // R10 stored-only registers
        wr(1, 8'h08, 32'h1234_5678);
        wr(1, 8'h0C, 32'h9ABC_DEF0);
        wr(1, 8'h58, 32'hFFFF_FFFF);
        chk(1, 8'h08, 32'h1234_5678, "R10 route 0 readback");
        chk(1, 8'h0C, 32'h9ABC_DEF0, "R10 route 1 readback");
        chk(1, 8'h58, 32'hFFFF_FFFF, "R10 polarity readback");
        settle(2);
        chk(1, 8'h50, 32'h0000_0800, "R10 polarity leaves status");
        chk(2, 8'h00, 32'h1, "R10 polarity leaves irq");

        // R11 / R7 ignored writes
        wr(1, 8'h5C, 32'h0);
        chk(1, 8'h5C, 32'h0000_0800, "R7 input register is read-only");
        wr(0, 8'h3C, 32'h0);
        wr(1, 8'h10, 32'h0);
        chk(0, 8'h34, 32'hFFFF_8000, "R11 unmapped write leaves mask");
        chk(1, 8'h54, 32'h0000_0800, "R11 unmapped write leaves s2 mask");

        // cleanup
        @(negedge clk);
        ser_irq[3] = 1'b0;
        wr(0, 8'h38, 32'hFFFF_FFFF);
        settle(2);
        wr(1, 8'h50, 32'hFFFF_FFFF);
        settle(1);
        chk(2, 8'h00, 32'h0, "R9 irq low after full acknowledge");

        settle(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule